// File: doc/BRIEF.md
# Flag-Producing Barrel Shifter

This block is a purely combinational shifter for a 32-bit integer datapath. In a single pass it performs a logical shift left, a logical shift right or an arithmetic shift right. The shift count comes from a six-bit operand, so it can run from 0 to 63. Alongside the shifted word the block produces the condition flags an execution stage writes back: carry, extend, negative, zero and overflow.

Counts are never reduced modulo the word width. A count of zero passes the operand through and keeps the incoming carry and extend flags. A count of exactly the word width has its own carry rule, and so does any count beyond the word width. The block sits between the operand fetch and the flag write-back of an integer pipeline and has no state.

Top module: `bshift_cc`

## Requirements
- R1: With a count of 0, the result equals the input value, the carry output equals the incoming carry, and the extend output equals the incoming extend.
- R2: A logical left shift by a count of 1 to 31 gives value << count. The carry is input bit (32 - count).
- R3: A right shift by a count of 1 to 31 gives value >> count. The carry is input bit (count - 1). The logical form fills the vacated bits with 0. The arithmetic form fills them with input bit 31.
- R4: A logical shift by exactly 32 gives a result of 0. The carry is input bit 0 for a left shift and input bit 31 for a right shift.
- R5: A logical shift, in either direction, by a count of 33 to 63 gives a result of 0 and a carry of 0.
- R6: An arithmetic right shift by a count of 32 to 63 sets every result bit to input bit 31. The carry also equals input bit 31.
- R7: For every nonzero count and every shift kind, the extend output equals the carry output.
- R8: The negative flag is result bit 31. The zero flag is 1 exactly when the result is all zeros. The overflow flag is always 0.
- R9: The shift kind is decoded from in_kind as follows: 2'b00 selects logical left, 2'b01 selects logical right, and both 2'b10 and 2'b11 select arithmetic right.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_value | input | 32 | Operand to be shifted |
| in_count | input | 6 | Shift count, 0 to 63 |
| in_kind | input | 2 | Shift kind select (see R9) |
| in_c | input | 1 | Incoming carry flag |
| in_x | input | 1 | Incoming extend flag |
| out_result | output | 32 | Shifted word |
| out_c | output | 1 | Carry flag |
| out_x | output | 1 | Extend flag |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |

## Verification
Directed vectors sweep the counts 0, 1, 31, 32, 33 and 63 for each shift kind. These counts separate the four carry regimes: pass-through, last bit shifted out, exactly the word width, and beyond the word width.

Operands with only bit 0 set, only bit 31 set, alternating bit patterns, and all ones make a carry taken from the wrong bit position visible. They also show a wrong fill bit, and the negative-operand cases distinguish logical from arithmetic fill. Vectors with in_kind set to 2'b11 confirm that code is decoded as arithmetic, and vectors with differing incoming carry and extend values confirm that a zero count leaves both unchanged. A long run of random operands, counts and kinds then covers the remaining combinations.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

   typedef enum logic [1:0] {
      SHK_LSL     = 2'b00,
      SHK_LSR     = 2'b01,
      SHK_ASR     = 2'b10,
      SHK_ASR_ALT = 2'b11
   } shift_kind_e;

   // Any code with the upper bit set is arithmetic; arithmetic implies right.
   function automatic logic kind_is_arith(input logic [1:0] k);
      return k[1];
   endfunction

   function automatic logic kind_is_right(input logic [1:0] k);
      return k[1] | k[0];
   endfunction

endpackage

// File: rtl/bshift_lsl.sv
// Left shift core: the operand is extended by one bit above its MSB, so the
// bit that lands there after shifting is the last one shifted out.
module bshift_lsl #(
   parameter int WIDTH  = 32,
   parameter int CNT_W  = 6,
   parameter bit STAGED = 1'b1
) (
   input  logic [WIDTH-1:0] v,
   input  logic [CNT_W-1:0] cnt,
   output logic [WIDTH-1:0] res,
   output logic             cout
);
   localparam int EXT_W = WIDTH + 1;

   logic [EXT_W-1:0] wide;

   generate
      if (STAGED) begin : g_staged
         logic [EXT_W-1:0] st [0:CNT_W];
         assign st[0] = {1'b0, v};
         for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            assign st[k+1] = cnt[k] ? (st[k] << (1 << k)) : st[k];
         end
         assign wide = st[CNT_W];
      end else begin : g_flat
         assign wide = {1'b0, v} << cnt;
      end
   endgenerate

   assign res  = wide[WIDTH-1:0];
   assign cout = wide[WIDTH];

   always_comb begin
      if (cnt != '0 && int'(cnt) < WIDTH) begin
         a_r2_lsl_carry : assert (cout == v[WIDTH - int'(cnt)])
            else $error("R2 left carry not the last bit shifted out");
      end
   end

endmodule

// File: rtl/bshift_rsh.sv
// Right shift core: operand framed as {fill, v, guard}, arithmetic-shifted so
// the top bit replicates the fill; the guard position catches the carry.
module bshift_rsh #(
   parameter int WIDTH  = 32,
   parameter int CNT_W  = 6,
   parameter bit STAGED = 1'b1
) (
   input  logic [WIDTH-1:0] v,
   input  logic [CNT_W-1:0] cnt,
   input  logic             fill,
   output logic [WIDTH-1:0] res,
   output logic             cout
);
   localparam int FRM_W = WIDTH + 2;

   logic [FRM_W-1:0] framed;

   generate
      if (STAGED) begin : g_staged
         logic [FRM_W-1:0] st [0:CNT_W];
         assign st[0] = {fill, v, 1'b0};
         for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            assign st[k+1] = cnt[k] ? FRM_W'($signed(st[k]) >>> (1 << k)) : st[k];
         end
         assign framed = st[CNT_W];
      end else begin : g_flat
         assign framed = FRM_W'($signed({fill, v, 1'b0}) >>> cnt);
      end
   endgenerate

   assign res  = framed[WIDTH:1];
   assign cout = framed[0];

   always_comb begin
      if (cnt != '0 && int'(cnt) < WIDTH) begin
         a_r3_rsh_carry : assert (cout == v[int'(cnt) - 1])
            else $error("R3 right carry not input bit count-1");
      end
   end

endmodule

// File: rtl/bshift_flags.sv
module bshift_flags #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] res,
   input  logic             core_c,
   input  logic             cnt_zero,
   input  logic             in_c,
   input  logic             in_x,
   output logic             c,
   output logic             x,
   output logic             n,
   output logic             z,
   output logic             v
);
   assign c = cnt_zero ? in_c : core_c;
   assign x = cnt_zero ? in_x : core_c;
   assign n = res[WIDTH-1];
   assign z = (res == '0);
   assign v = 1'b0;
endmodule

// File: rtl/bshift_cc.sv
module bshift_cc
   import bshift_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int CNT_W  = 6,
   parameter bit STAGED = 1'b1
) (
   input  logic [WIDTH-1:0] in_value,
   input  logic [CNT_W-1:0] in_count,
   input  logic [1:0]       in_kind,
   input  logic             in_c,
   input  logic             in_x,
   output logic [WIDTH-1:0] out_result,
   output logic             out_c,
   output logic             out_x,
   output logic             out_n,
   output logic             out_z,
   output logic             out_v
);
   localparam int MAX_CNT = (1 << CNT_W) - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bshift_cc: WIDTH must be at least 2");
      end
      if (MAX_CNT <= WIDTH) begin : g_bad_cnt
         $error("bshift_cc: CNT_W must allow counts beyond WIDTH");
      end
   endgenerate

   logic             is_right, is_arith, cnt_zero;
   logic [WIDTH-1:0] l_res, r_res, core_res;
   logic             l_c, r_c, core_c;

   assign is_right = kind_is_right(in_kind);
   assign is_arith = kind_is_arith(in_kind);
   assign cnt_zero = (in_count == '0);

   bshift_lsl #(.WIDTH(WIDTH), .CNT_W(CNT_W), .STAGED(STAGED)) u_lsl (
      .v(in_value), .cnt(in_count), .res(l_res), .cout(l_c)
   );

   bshift_rsh #(.WIDTH(WIDTH), .CNT_W(CNT_W), .STAGED(STAGED)) u_rsh (
      .v(in_value), .cnt(in_count), .fill(is_arith & in_value[WIDTH-1]),
      .res(r_res), .cout(r_c)
   );

   assign core_res   = is_right ? r_res : l_res;
   assign core_c     = is_right ? r_c   : l_c;
   assign out_result = core_res;

   bshift_flags #(.WIDTH(WIDTH)) u_flags (
      .res(core_res), .core_c(core_c), .cnt_zero(cnt_zero),
      .in_c(in_c), .in_x(in_x),
      .c(out_c), .x(out_x), .n(out_n), .z(out_z), .v(out_v)
   );

   always_comb begin
      if (cnt_zero) begin
         a_r1_zero_pass : assert (out_result == in_value && out_c == in_c && out_x == in_x)
            else $error("R1 zero count did not pass through");
      end
      if (!cnt_zero) begin
         a_r7_x_follows_c : assert (out_x == out_c)
            else $error("R7 extend differs from carry");
      end
      if (!is_arith && int'(in_count) > WIDTH) begin
         a_r5_far_logical : assert (out_result == '0 && !out_c)
            else $error("R5 far logical shift not cleared");
      end
      if (is_arith && int'(in_count) >= WIDTH) begin
         a_r6_asr_sat : assert (out_result == {WIDTH{in_value[WIDTH-1]}} && out_c == in_value[WIDTH-1])
            else $error("R6 arithmetic saturation wrong");
      end
      if (!is_arith && int'(in_count) == WIDTH) begin
         a_r4_exact_width : assert (out_result == '0)
            else $error("R4 exact-width logical result not zero");
      end
   end

endmodule

// File: tb/bshift_cc_tb.sv
module bshift_cc_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [31:0] res;
      logic        c, x, n, z, v;
      string       tag;
      string       xtag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] in_value = '0;
   logic [5:0]  in_count = '0;
   logic [1:0]  in_kind  = '0;
   logic        in_c = 1'b0, in_x = 1'b0;
   logic [31:0] out_result;
   logic        out_c, out_x, out_n, out_z, out_v;

   int checks = 0;
   int errors = 0;
   exp_t q[$];
   exp_t mon_e;
   bit   done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bshift_cc u_dut (
      .in_value(in_value), .in_count(in_count), .in_kind(in_kind),
      .in_c(in_c), .in_x(in_x), .out_result(out_result),
      .out_c(out_c), .out_x(out_x), .out_n(out_n), .out_z(out_z), .out_v(out_v)
   );

   function automatic exp_t model(input logic [31:0] v, input int n,
                                  input logic [1:0] k, input logic ci, input logic xi);
      exp_t e;
      logic arith = k[1];
      logic right = k[1] | k[0];
      e.tag = "";
      if (n == 0) begin
         e.res = v; e.c = ci; e.x = xi; e.tag = "R1"; e.xtag = "R1";
      end else begin
         if (!right) begin
            if (n < 32)       begin e.res = v << n; e.c = v[32-n]; e.tag = "R2"; end
            else if (n == 32) begin e.res = '0; e.c = v[0]; e.tag = "R4"; end
            else              begin e.res = '0; e.c = 1'b0; e.tag = "R5"; end
         end else if (!arith) begin
            if (n < 32)       begin e.res = v >> n; e.c = v[n-1]; e.tag = "R3"; end
            else if (n == 32) begin e.res = '0; e.c = v[31]; e.tag = "R4"; end
            else              begin e.res = '0; e.c = 1'b0; e.tag = "R5"; end
         end else begin
            if (n < 32) begin e.res = 32'($signed(v) >>> n); e.c = v[n-1]; e.tag = "R3"; end
            else        begin e.res = {32{v[31]}}; e.c = v[31]; e.tag = "R6"; end
         end
         e.x = e.c; e.xtag = "R7";
      end
      if (k == 2'b11) e.tag = {e.tag, "/R9"};
      e.n = e.res[31];              // R8
      e.z = (e.res == 32'd0);
      e.v = 1'b0;
      return e;
   endfunction

   task automatic drive(input logic [31:0] v, input int n, input logic [1:0] k,
                        input logic ci, input logic xi);
      @(posedge clk);
      #1;
      in_value = v; in_count = 6'(n); in_kind = k; in_c = ci; in_x = xi;
      q.push_back(model(v, n, k, ci, xi));
   endtask

   task automatic cmp(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Monitor: results of the vector driven after a rising edge are compared
   // at the following falling edge, when the combinational outputs have settled.
   always @(negedge clk) begin
      if (q.size() != 0) begin
         mon_e = q.pop_front();
         cmp(mon_e.tag,  "result", out_result, mon_e.res);
         cmp(mon_e.tag,  "carry",  {31'd0, out_c}, {31'd0, mon_e.c});
         cmp(mon_e.xtag, "extend", {31'd0, out_x}, {31'd0, mon_e.x});
         cmp("R8", "negative", {31'd0, out_n}, {31'd0, mon_e.n});
         cmp("R8", "zero",     {31'd0, out_z}, {31'd0, mon_e.z});
         cmp("R8", "overflow", {31'd0, out_v}, {31'd0, mon_e.v});
      end
   end

   initial begin
      int cnts [6] = '{0, 1, 31, 32, 33, 63};
      logic [31:0] pats [5] = '{32'h0000_0001, 32'h8000_0000, 32'hAAAA_AAAA,
                                32'h5555_5555, 32'hFFFF_FFFF};
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // Reset state: all-zero inputs give zero result, Z set (R1, R8)
      drive(32'd0, 0, 2'b00, 1'b0, 1'b0);
      // R1: zero count keeps carry and extend, with differing values
      drive(32'h1234_5678, 0, 2'b00, 1'b1, 1'b0);
      drive(32'h8765_4321, 0, 2'b10, 1'b0, 1'b1);
      drive(32'hF000_000F, 0, 2'b01, 1'b1, 1'b1);
      // Directed sweep over kinds, counts and patterns (R2..R7, R9)
      for (int k = 0; k < 4; k++)
         for (int ci = 0; ci < 6; ci++)
            for (int pi = 0; pi < 5; pi++)
               drive(pats[pi], cnts[ci], 2'(k), pi[0], ~pi[0]);
      // R2/R3 single-bit walk of the carry position
      for (int n = 1; n < 32; n++) begin
         drive(32'h1 << (32 - n), n, 2'b00, 1'b0, 1'b0);
         drive(32'h1 << (n - 1), n, 2'b01, 1'b0, 1'b0);
         drive(32'h8000_0000 | (32'h1 << (n - 1)), n, 2'b10, 1'b0, 1'b0);
      end
      // Random coverage
      for (int i = 0; i < 600; i++)
         drive($urandom, int'($urandom_range(0, 63)), 2'($urandom_range(0, 3)),
               1'($urandom), 1'($urandom));
      @(posedge clk);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule